// File: doc/BRIEF.md
# Address Translation Buffer with Access Guard and Modified-Page Tracking

The block caches recent page mappings so that a virtual address can be turned into a physical one in a single cycle. It is fully associative and holds a parameter-sized set of mappings (eight by default). Each request carries a virtual address, an access kind (read, write or instruction fetch) and the privilege level of the requester. A mapping that is present is checked against its permission bits before any address is released. The access then either produces a physical address or is rejected with a protection fault.

When no mapping matches, the block raises a request to an external page-table port and holds off new requests. If the reply marks the page resident, the block installs it and repeats the lookup internally. Otherwise it reports a page fault and keeps nothing. Each cached mapping records whether the page has been written. A modified mapping that is pushed out, either by replacement or by a flush, is reported on a separate write-back port so the page table can record the change.

Top module: `tlb_xlate`

## Requirements
- R1: A request accepted (reqValid and reqReady high at a clock edge) that matches a cached mapping and passes the permission check raises respValid for one cycle, starting one cycle after acceptance. respStatus is 0 (success) and respPaddr is the cached physical page number concatenated with the untouched low 12 address bits.
- R2: An accepted request with no matching mapping raises ptwReqValid one cycle after acceptance, carrying the request's virtual page number on ptwReqVpn. Both stay steady until ptwRespValid. reqReady stays low until the miss is resolved, so at most one miss is outstanding.
- R3: A page-table reply with ptwRespResident low produces respValid with respStatus 2 (page fault) one cycle after the reply. No mapping is installed, so the same page misses again on its next access.
- R4: A page-table reply with ptwRespResident high installs the mapping with its dirty mark clear. The lookup is then repeated, and its result appears two cycles after the reply.
- R5: reqKind encodes 0 read, 1 write and 2 fetch. ptwRespPerm bit 0 grants read, bit 1 grants write and bit 2 grants fetch. A hit whose kind is not granted returns respStatus 1 (protection fault).
- R6: ptwRespPerm bit 3 marks a page open to user mode. When reqSuper is 0 and bit 3 is clear, the access returns respStatus 1. When reqSuper is 1, bit 3 is ignored.
- R7: A permitted write that hits a mapping marks that mapping dirty. This includes the repeated lookup after a refill. A denied write leaves the mark unchanged.
- R8: Replacement picks the lowest-numbered empty slot if one exists. Otherwise it picks the slot least recently used, where any hit counts as a use, permitted or not, and so does an install. Evicting a valid dirty mapping pulses wbValid, wbVpn and wbPpn one cycle after the install. Evicting a clean mapping produces no pulse.
- R9: A flush walks slots 0 to N-1, one per cycle. For each slot that is valid and dirty it pulses wbValid with that slot's page numbers, then it invalidates every slot. reqReady is low from the flush edge until the walk ends, and every page misses afterwards.
- R10: When flush is high, reqReady is low, so a request offered in the same cycle as a flush is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Start a write-back-and-invalidate walk |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqVaddr | input | 32 | Virtual address |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch |
| reqSuper | input | 1 | 1 for supervisor mode, 0 for user mode |
| respValid | output | 1 | Result pulse |
| respStatus | output | 2 | 0 success, 1 protection fault, 2 page fault |
| respPaddr | output | 32 | Physical address, meaningful on success |
| ptwReqValid | output | 1 | Page-table lookup pending |
| ptwReqVpn | output | 20 | Virtual page number to look up |
| ptwRespValid | input | 1 | Page-table reply pulse |
| ptwRespResident | input | 1 | Page is in memory |
| ptwRespPpn | input | 20 | Physical page number from the page table |
| ptwRespPerm | input | 4 | Bit 0 read, bit 1 write, bit 2 fetch, bit 3 user |
| wbValid | output | 1 | Dirty mapping leaving the buffer |
| wbVpn | output | 20 | Virtual page of the departing mapping |
| wbPpn | output | 20 | Physical page of the departing mapping |

## Verification
A hit answers one cycle after its accept edge. A miss raises its page-table request at that same point. A non-resident reply answers one cycle after the reply edge. A resident reply shows its write-back pulse one cycle after the reply edge and its answer one cycle later. A flush's write-back for slot k appears k+2 cycles after the flush edge. The bench drives at falling edges and samples at the falling edge of exactly the cycle where each result falls due. In every other cycle of a transaction it also checks that respValid and wbValid stay low. It predicts victims, dirty marks and permissions with a timestamp model of recency that does not mirror the hardware's age counters.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_PROT = 2'd1,
    ST_PAGE = 2'd2
  } status_e;

  // strobes from the sequencer to the mapping store
  typedef struct packed {
    logic capture;   // latch the incoming request
    logic useHeld;   // look up with the latched request
    logic access;    // lookup cycle: record use, set dirty
    logic install;   // write the page-table reply into the victim slot
    logic clearOne;  // flush walk: drop the slot at flushIdx
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFS_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strb,
  input  logic [VPN_W-1:0]   liveVpn,
  input  logic [OFS_W-1:0]   liveOfs,
  input  logic [1:0]         liveKind,
  input  logic               liveSup,
  input  logic [IDX_W-1:0]   flushIdx,
  input  logic [PPN_W-1:0]   ptwPpn,
  input  logic [3:0]         ptwPerm,
  output logic               hit,
  output logic               permOk,
  output logic               wbCand,
  output logic [VPN_W-1:0]   heldVpn,
  output logic [PPN_W+OFS_W-1:0] respPaddr,
  output logic [VPN_W-1:0]   wbVpn,
  output logic [PPN_W-1:0]   wbPpn
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] eValid, eDirty, matchVec;
  logic [VPN_W-1:0]   eVpn  [ENTRIES];
  logic [PPN_W-1:0]   ePpn  [ENTRIES];
  logic [3:0]         ePerm [ENTRIES];
  logic [IDX_W-1:0]   eAge  [ENTRIES];

  logic [OFS_W-1:0] hOfs;
  logic [1:0]       hKind;
  logic             hSup;

  logic [VPN_W-1:0] curVpn;
  logic [OFS_W-1:0] curOfs;
  logic [1:0]       curKind;
  logic             curSup;
  logic [IDX_W-1:0] hitIdx, freeIdx, oldIdx, vicIdx, selIdx, touchIdx, refAge;
  logic             touchEn;

  assign curVpn  = strb.useHeld ? heldVpn : liveVpn;
  assign curOfs  = strb.useHeld ? hOfs    : liveOfs;
  assign curKind = strb.useHeld ? hKind   : liveKind;
  assign curSup  = strb.useHeld ? hSup    : liveSup;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = eValid[g] && (eVpn[g] == curVpn);
  end

  assign hit = |matchVec;

  always_comb begin
    hitIdx = '0;
    oldIdx = '0;
    freeIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
      if (eAge[i] == OLDEST) oldIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!eValid[i]) freeIdx = IDX_W'(i);
    end
  end

  assign vicIdx = (&eValid) ? oldIdx : freeIdx;
  assign permOk = (curKind != 2'd3) && ePerm[hitIdx][curKind] && (curSup || ePerm[hitIdx][3]);
  assign selIdx = strb.clearOne ? flushIdx : vicIdx;
  assign wbCand = eValid[selIdx] && eDirty[selIdx];
  assign touchEn  = (strb.access && hit) || strb.install;
  assign touchIdx = strb.install ? vicIdx : hitIdx;
  assign refAge   = eAge[touchIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eValid    <= '0;
      eDirty    <= '0;
      heldVpn   <= '0;
      hOfs      <= '0;
      hKind     <= '0;
      hSup      <= 1'b0;
      respPaddr <= '0;
      wbVpn     <= '0;
      wbPpn     <= '0;
      for (int i = 0; i < ENTRIES; i++) eAge[i] <= IDX_W'(i);
    end else begin
      if (strb.capture) begin
        heldVpn <= liveVpn;
        hOfs    <= liveOfs;
        hKind   <= liveKind;
        hSup    <= liveSup;
      end
      if (strb.access && hit) begin
        respPaddr <= {ePpn[hitIdx], curOfs};
        if (curKind == ACC_WRITE && permOk) eDirty[hitIdx] <= 1'b1;
      end
      if (strb.install || strb.clearOne) begin
        wbVpn <= eVpn[selIdx];
        wbPpn <= ePpn[selIdx];
      end
      if (strb.install) begin
        eValid[vicIdx] <= 1'b1;
        eDirty[vicIdx] <= 1'b0;
        eVpn[vicIdx]   <= heldVpn;
        ePpn[vicIdx]   <= ptwPpn;
        ePerm[vicIdx]  <= ptwPerm;
      end
      if (strb.clearOne) begin
        eValid[flushIdx] <= 1'b0;
        eDirty[flushIdx] <= 1'b0;
      end
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx) eAge[i] <= '0;
          else if (eAge[i] < refAge) eAge[i] <= eAge[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             reqValid,
  input  logic             hit,
  input  logic             permOk,
  input  logic             wbCand,
  input  logic             ptwRespValid,
  input  logic             ptwResident,
  output tlbStrobes_t      strb,
  output logic             reqReady,
  output logic             respValid,
  output logic [1:0]       respStatus,
  output logic             ptwReqValid,
  output logic             wbValid,
  output logic [IDX_W-1:0] flushIdx
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RETRY, S_FLUSH} state_e;
  state_e state;

  assign reqReady = (state == S_IDLE) && !flush;

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:  if (!flush && reqValid) begin
                 strb.capture = 1'b1;
                 strb.access  = 1'b1;
               end
      S_WAIT:  strb.install = ptwRespValid && ptwResident;
      S_RETRY: begin
                 strb.useHeld = 1'b1;
                 strb.access  = 1'b1;
               end
      S_FLUSH: strb.clearOne = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      respValid   <= 1'b0;
      respStatus  <= ST_OK;
      ptwReqValid <= 1'b0;
      wbValid     <= 1'b0;
      flushIdx    <= '0;
    end else begin
      respValid <= 1'b0;
      wbValid   <= (strb.install || strb.clearOne) && wbCand;
      case (state)
        S_IDLE: begin
          if (flush) begin
            state    <= S_FLUSH;
            flushIdx <= '0;
          end else if (reqValid) begin
            if (hit) begin
              respValid  <= 1'b1;
              respStatus <= permOk ? ST_OK : ST_PROT;
            end else begin
              ptwReqValid <= 1'b1;
              state       <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (ptwRespValid) begin
            ptwReqValid <= 1'b0;
            if (ptwResident) state <= S_RETRY;
            else begin
              respValid  <= 1'b1;
              respStatus <= ST_PAGE;
              state      <= S_IDLE;
            end
          end
        end
        S_RETRY: begin
          respValid  <= 1'b1;
          respStatus <= (hit && permOk) ? ST_OK : ST_PROT;
          state      <= S_IDLE;
        end
        S_FLUSH: begin
          flushIdx <= flushIdx + 1'b1;
          if (flushIdx == IDX_W'(ENTRIES - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFS_W   = 12,
  localparam int VA_W   = VPN_W + OFS_W,
  localparam int PA_W   = PPN_W + OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic             reqSuper,
  output logic             respValid,
  output logic [1:0]       respStatus,
  output logic [PA_W-1:0]  respPaddr,
  output logic             ptwReqValid,
  output logic [VPN_W-1:0] ptwReqVpn,
  input  logic             ptwRespValid,
  input  logic             ptwRespResident,
  input  logic [PPN_W-1:0] ptwRespPpn,
  input  logic [3:0]       ptwRespPerm,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn,
  output logic [PPN_W-1:0] wbPpn
);
  tlbStrobes_t      strb;
  logic             hit, permOk, wbCand;
  logic [IDX_W-1:0] flushIdx;

  tlb_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk, .rstN, .flush, .reqValid, .hit, .permOk, .wbCand,
    .ptwRespValid, .ptwResident(ptwRespResident), .strb, .reqReady,
    .respValid, .respStatus, .ptwReqValid, .wbValid, .flushIdx
  );

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFS_W(OFS_W)) i_store (
    .clk, .rstN, .strb,
    .liveVpn(reqVaddr[VA_W-1:OFS_W]), .liveOfs(reqVaddr[OFS_W-1:0]),
    .liveKind(reqKind), .liveSup(reqSuper), .flushIdx,
    .ptwPpn(ptwRespPpn), .ptwPerm(ptwRespPerm),
    .hit, .permOk, .wbCand, .heldVpn(ptwReqVpn), .respPaddr, .wbVpn, .wbPpn
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             reqReady,
  input logic             respValid,
  input logic [1:0]       respStatus,
  input logic             ptwReqValid,
  input logic [VPN_W-1:0] ptwReqVpn,
  input logic             ptwRespValid,
  input logic             ptwRespResident,
  input logic             wbValid
);
  AST_PT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ptwReqValid && !ptwRespValid |=> ptwReqValid && $stable(ptwReqVpn)); // R2
  AST_SINGLE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    ptwReqValid |-> !reqReady); // R2
  AST_PAGE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respStatus == 2'd2 |-> $past(ptwRespValid && !ptwRespResident)); // R3
  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ptwReqValid && !ptwRespValid |=> !respValid); // R4
  AST_WB_BUSY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !$past(reqReady)); // R8
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !reqReady); // R10
endmodule

bind tlb_xlate tlb_xlate_chk #(.VPN_W(VPN_W)) i_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .reqReady(reqReady),
  .respValid(respValid), .respStatus(respStatus), .ptwReqValid(ptwReqValid),
  .ptwReqVpn(ptwReqVpn), .ptwRespValid(ptwRespValid),
  .ptwRespResident(ptwRespResident), .wbValid(wbValid)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, reqValid = 1'b0, reqSuper = 1'b0;
  logic reqReady, respValid, ptwReqValid, wbValid;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0, respStatus;
  logic [31:0] respPaddr;
  logic [19:0] ptwReqVpn, wbVpn, wbPpn;
  logic        ptwRespValid = 1'b0, ptwRespResident = 1'b0;
  logic [19:0] ptwRespPpn = '0;
  logic [3:0]  ptwRespPerm = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural model: slots with timestamps of last use
  int mV[8], mD[8], mVpn[8], mPpn[8], mPerm[8], mStamp[8];
  int now = 0;

  always #4 clk = ~clk;

  tlb_xlate i_tlb_xlate (.*);

  task automatic chkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    now++;
  endtask

  function automatic int ptResident(int vpn); return (vpn & 'hF) != 'hF; endfunction
  function automatic int ptPpn(int vpn); return (vpn ^ 'h5A5A5) & 'hFFFFF; endfunction
  function automatic int ptPerm(int vpn);
    return (((vpn >> 4) & 1) == 0 ? 1 : 0) | (((vpn & 1) == 0) ? 2 : 0)
         | ((((vpn >> 1) & 1) == 1) ? 4 : 0) | ((((vpn >> 2) & 1) == 0) ? 8 : 0);
  endfunction

  function automatic int mFind(int vpn);
    for (int i = 0; i < 8; i++) if (mV[i] != 0 && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int mVictim();
    int best = 0;
    for (int i = 0; i < 8; i++) if (mV[i] == 0) return i;
    for (int i = 1; i < 8; i++) if (mStamp[i] < mStamp[best]) best = i;
    return best;
  endfunction

  function automatic bit mAllowed(int perm, int kind, bit sup);
    return (((perm >> kind) & 1) == 1) && (sup || ((perm >> 3) & 1) == 1);
  endfunction

  // result of a lookup that hits slot i (R1, R5, R6, R7)
  task automatic finishHit(int i, int ofs, int kind, bit sup, string req);
    bit ok = mAllowed(mPerm[i], kind, sup);
    chkEq(req, "respValid", respValid, 1);
    chkEq(ok ? req : (sup ? "R5" : "R6"), "respStatus", respStatus, ok ? 0 : 1);
    if (ok) chkEq("R1", "respPaddr", respPaddr, (longint'(mPpn[i]) << 12) | ofs);
    chkEq("R8", "wbValid idle", wbValid, 0);
    mStamp[i] = now;
    if (ok && kind == 1) mD[i] = 1;
  endtask

  task automatic doAccess(int vpn, int ofs, int kind, bit sup);
    int hi = mFind(vpn);
    chkEq("R2", "reqReady before request", reqReady, 1);
    reqVaddr = 32'((vpn << 12) | ofs);
    reqKind = 2'(kind);
    reqSuper = sup;
    reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    if (hi >= 0) begin
      finishHit(hi, ofs, kind, sup, "R1");
    end else begin
      chkEq("R2", "respValid on miss", respValid, 0);
      chkEq("R2", "ptwReqValid", ptwReqValid, 1);
      chkEq("R2", "ptwReqVpn", ptwReqVpn, vpn);
      chkEq("R2", "reqReady during miss", reqReady, 0);
      repeat (2) begin
        tick();
        chkEq("R2", "ptwReqValid held", ptwReqValid, 1);
        chkEq("R4", "respValid while waiting", respValid, 0);
      end
      ptwRespValid = 1'b1;
      ptwRespResident = ptResident(vpn) != 0;
      ptwRespPpn = 20'(ptPpn(vpn));
      ptwRespPerm = 4'(ptPerm(vpn));
      tick();
      ptwRespValid = 1'b0;
      chkEq("R2", "ptwReqValid dropped", ptwReqValid, 0);
      if (ptResident(vpn) == 0) begin
        chkEq("R3", "respValid page fault", respValid, 1);
        chkEq("R3", "respStatus page fault", respStatus, 2);
        chkEq("R3", "wbValid", wbValid, 0);
      end else begin
        int v = mVictim();
        bit expWb = mV[v] != 0 && mD[v] != 0;
        chkEq("R8", "wbValid on eviction", wbValid, expWb);
        if (expWb) begin
          chkEq("R8", "wbVpn", wbVpn, mVpn[v]);
          chkEq("R8", "wbPpn", wbPpn, mPpn[v]);
        end
        chkEq("R4", "respValid at install", respValid, 0);
        mV[v] = 1; mD[v] = 0; mVpn[v] = vpn; mPpn[v] = ptPpn(vpn);
        mPerm[v] = ptPerm(vpn); mStamp[v] = now;
        tick();
        finishHit(v, ofs, kind, sup, "R4");
      end
    end
    tick();
    chkEq("R1", "respValid is a pulse", respValid, 0);
  endtask

  task automatic doFlush(bit withReq);
    flush = 1'b1;
    if (withReq) begin
      reqVaddr = 32'h0007_7000;
      reqKind = 2'd0;
      reqValid = 1'b1;
    end
    #1;
    chkEq("R10", "reqReady with flush", reqReady, 0);
    tick();
    flush = 1'b0;
    reqValid = 1'b0;
    chkEq("R10", "no response to request offered with flush", respValid, 0);
    chkEq("R9", "reqReady in walk", reqReady, 0);
    for (int i = 0; i < 8; i++) begin
      bit expWb = mV[i] != 0 && mD[i] != 0;
      tick();
      chkEq("R9", "wbValid in walk", wbValid, expWb);
      if (expWb) begin
        chkEq("R9", "wbVpn in walk", wbVpn, mVpn[i]);
        chkEq("R9", "wbPpn in walk", wbPpn, mPpn[i]);
      end
      chkEq("R9", "reqReady at walk step", reqReady, i == 7);
      chkEq("R9", "respValid in walk", respValid, 0);
      mV[i] = 0;
      mD[i] = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mV[i] = 0; mD[i] = 0; mStamp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "reset respValid", respValid, 0);
    chkEq("R2", "reset ptwReqValid", ptwReqValid, 0);
    chkEq("R2", "reset reqReady", reqReady, 1);
    chkEq("R8", "reset wbValid", wbValid, 0);

    doAccess('h20, 'h123, 0, 0);   // miss, install, success (R4)
    doAccess('h20, 'hABC, 0, 0);   // hit (R1)
    doAccess('h20, 'h004, 1, 0);   // write hit sets dirty (R7)
    doAccess('h20, 'h000, 2, 0);   // fetch not granted (R5)
    doAccess('h24, 'h010, 0, 0);   // supervisor-only page from user (R6)
    doAccess('h24, 'h010, 0, 1);   // supervisor passes (R6)
    doAccess('h24, 'h020, 1, 1);   // dirty (R7)
    doAccess('h21, 'h030, 1, 0);   // write denied, stays clean (R7)
    doAccess('h2F, 'h040, 0, 1);   // not resident (R3)
    doAccess('h2F, 'h040, 0, 1);   // misses again (R3)
    doAccess('h12, 'h050, 2, 0);   // fetch granted
    doAccess('h12, 'h050, 0, 0);   // read not granted (R5)
    doAccess('h40, 'h001, 0, 1);
    doAccess('h42, 'h002, 0, 1);
    doAccess('h44, 'h003, 0, 1);
    doAccess('h46, 'h004, 0, 1);   // buffer full
    doAccess('h48, 'h005, 0, 1);   // evicts dirty 0x20 (R8)
    doAccess('h4A, 'h006, 0, 1);   // evicts dirty 0x24 (R8)
    doAccess('h4C, 'h007, 0, 1);   // evicts clean 0x21 (R8)
    doAccess('h40, 'h008, 1, 1);   // dirty (R7)
    doFlush(1);                    // R9, R10
    doAccess('h40, 'h009, 0, 1);   // misses after flush (R9)
    doAccess('h60, 'h00A, 1, 1);   // dirty set by retry (R7)
    doFlush(0);                    // R9

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule